// File: doc/BRIEF.md
# Tiled Two-Mode Convolution Actor

This block is a dataflow actor that filters image tiles with a small two-dimensional kernel. It works in two modes. In the loading mode it drains a coefficient vector from a coefficient FIFO. The vector holds a row count, a column count and then the kernel taps. The block keeps the taps and their running sum. In the processing mode it reads one padded input tile from a tile FIFO into a local buffer. It then convolves the buffered tile with the stored kernel and writes a tile without the padding to an output FIFO, one pixel at a time.

Every output pixel is a weighted sum of a kernel-sized window. A tree of parallel multipliers and adders forms the sum in a single cycle. A sequential divider then divides the sum by the tap sum, which makes the kernel behave as though its taps sum to one. Once loaded, the kernel stays in place for any number of tiles. The only way to install a different kernel is the external `reload` input, which returns the actor to the loading mode between tiles.

Top module: `conv_tile_actor`

## Requirements
- R1: After reset the actor is in the loading mode (`proc_mode` = 0) with `out_wr` low, and it pops no tile tokens while in that mode.
- R2: In the loading mode the coefficient FIFO is popped only while it is non-empty. The vector is read in this order: first the row count, then the column count, then rows×cols taps in row-major order. Tap (r,c) is used as kernel weight k[r][c].
- R3: After the last tap of a vector is read, `proc_mode` goes to 1 and stays at 1. While it is 1, no coefficient token is popped and the stored kernel is unchanged.
- R4: In the processing mode the tile FIFO is popped only while it is non-empty. A tile is (TILE_W+2·HALO)·(TILE_H+2·HALO) pixels in raster order, and input pixel p[i] has row stride TILE_W+2·HALO.
- R5: Output pixel (x,y) equals floor((A + S/2) / S). Here A = Σ k[yf][xf]·p[(y+yf)·(TILE_W+2·HALO) + x+xf], summed over the loaded rows and columns, and S is the sum of all loaded taps.
- R6: When S = 0, every output pixel is 0.
- R7: Each tile produces TILE_W·TILE_H output writes in raster order, with x changing fastest. No write occurs before the last pixel of that tile has been popped.
- R8: `out_wr` is a single-cycle pulse. It is never high in a cycle that follows a cycle with `out_full` high, and a stall never loses or reorders pixels.
- R9: `reload` returns the actor to the loading mode only while it is in the processing mode with no tile in progress. The next vector then replaces the whole kernel. A `reload` raised while a tile is being read has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reload | input | 1 | Request to return to the loading mode |
| coef_empty | input | 1 | Coefficient FIFO is empty |
| coef_rd | output | 1 | Pop strobe for the coefficient FIFO |
| coef_din | input | COEF_W | Head token of the coefficient FIFO |
| tile_empty | input | 1 | Tile FIFO is empty |
| tile_rd | output | 1 | Pop strobe for the tile FIFO |
| tile_din | input | PIX_W | Head pixel of the tile FIFO |
| out_full | input | 1 | Output FIFO is full |
| out_wr | output | 1 | Output FIFO write strobe (registered) |
| out_dout | output | PIX_W | Output pixel (registered) |
| proc_mode | output | 1 | Current mode: 0 = loading, 1 = processing |

## Verification
With the default sizes, the first output write comes 34 cycles after the edge that pops a tile's last pixel. Each later write follows the previous one by 34 cycles, plus one cycle for every cycle spent behind a full output FIFO. That figure is 4 cycles around a 30-step divider. A mode change shows on `proc_mode` one cycle after the last tap is popped or after an accepted `reload`. Because the write times depend on the divider length and on backpressure, the bench does not wait a fixed number of cycles. Instead it pushes the expected pixels into a queue as it drives each tile, and a monitor compares them against the writes it samples on falling edges. The same monitor checks the position of each write relative to the tile pops and to the `out_full` value of the previous cycle.

// File: rtl/conv_actor_pkg.sv
`timescale 1ns/1ps
package conv_actor_pkg;

  typedef enum logic [1:0] {
    CP_ROWS,
    CP_COLS,
    CP_TAPS,
    CP_HELD
  } coef_phase_e;

  typedef enum logic [2:0] {
    EN_FILL,
    EN_MAC,
    EN_DIVGO,
    EN_DIVWAIT,
    EN_EMIT
  } eng_state_e;

  // ceil(log2(v)), but never below one bit
  function automatic int clog2m(input int v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction

endpackage

// File: rtl/conv_coef_store.sv
`timescale 1ns/1ps
module conv_coef_store
  import conv_actor_pkg::*;
#(
  parameter int COEF_W = 16,
  parameter int KMAX   = 5,
  parameter int SUM_W  = 21
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clear,
  input  logic                       fifo_empty,
  output logic                       fifo_rd,
  input  logic [COEF_W-1:0]          fifo_din,
  output logic [KMAX*KMAX*COEF_W-1:0] taps,
  output logic [SUM_W-1:0]           tap_sum,
  output logic                       held
);
  localparam int RW = clog2m(KMAX);
  localparam logic [COEF_W-1:0] KMAX_C = COEF_W'(KMAX);

  coef_phase_e       phase;
  logic [COEF_W-1:0] rows_q, cols_q, r_q, c_q;
  logic [COEF_W-1:0] tap_q [KMAX][KMAX];
  logic [SUM_W-1:0]  sum_q;

  assign fifo_rd = (phase != CP_HELD) && !fifo_empty;
  assign held    = (phase == CP_HELD);
  assign tap_sum = sum_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= CP_ROWS;
      rows_q <= '0;
      cols_q <= '0;
      r_q    <= '0;
      c_q    <= '0;
      sum_q  <= '0;
      for (int i = 0; i < KMAX; i++)
        for (int j = 0; j < KMAX; j++)
          tap_q[i][j] <= '0;
    end else if (clear && phase == CP_HELD) begin
      phase <= CP_ROWS;
    end else if (fifo_rd) begin
      case (phase)
        CP_ROWS: begin
          rows_q <= fifo_din;
          sum_q  <= '0;
          for (int i = 0; i < KMAX; i++)
            for (int j = 0; j < KMAX; j++)
              tap_q[i][j] <= '0;
          phase <= CP_COLS;
        end
        CP_COLS: begin
          cols_q <= fifo_din;
          r_q    <= '0;
          c_q    <= '0;
          phase  <= (rows_q == '0 || fifo_din == '0) ? CP_HELD : CP_TAPS;
        end
        CP_TAPS: begin
          if (r_q < KMAX_C && c_q < KMAX_C) begin
            tap_q[r_q[RW-1:0]][c_q[RW-1:0]] <= fifo_din;
            sum_q <= sum_q + SUM_W'(fifo_din);
          end
          if (c_q == cols_q - 1'b1) begin
            c_q <= '0;
            if (r_q == rows_q - 1'b1) phase <= CP_HELD;
            else r_q <= r_q + 1'b1;
          end else begin
            c_q <= c_q + 1'b1;
          end
        end
        default: phase <= CP_HELD;
      endcase
    end
  end

  for (genvar gr = 0; gr < KMAX; gr++) begin : g_row
    for (genvar gc = 0; gc < KMAX; gc++) begin : g_col
      assign taps[(gr*KMAX+gc)*COEF_W +: COEF_W] = tap_q[gr][gc];
    end
  end

  // R3: once held, the kernel stays until an accepted reload
  a_r3_held_sticky: assert property (@(posedge clk) disable iff (rst)
    (phase == CP_HELD && !clear) |=> (phase == CP_HELD));
  // R2: taps are only read after a non-empty header
  a_r2_header_first: assert property (@(posedge clk) disable iff (rst)
    (phase == CP_TAPS) |-> (rows_q != '0 && cols_q != '0));

endmodule

// File: rtl/conv_tile_buf.sv
`timescale 1ns/1ps
module conv_tile_buf
  import conv_actor_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int ROW_W  = 8,
  parameter int N_IN   = 64,
  parameter int KMAX   = 5,
  parameter int XW     = 2,
  parameter int YW     = 2
) (
  input  logic                         clk,
  input  logic                         wr_en,
  input  logic [clog2m(N_IN)-1:0]      wr_addr,
  input  logic [PIX_W-1:0]             wr_data,
  input  logic [XW-1:0]                ox,
  input  logic [YW-1:0]                oy,
  output logic [KMAX*KMAX*PIX_W-1:0]   window
);
  localparam int AW = clog2m(N_IN);

  logic [PIX_W-1:0] mem [N_IN];
  logic [AW-1:0]    base;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign base = AW'(oy) * AW'(ROW_W) + AW'(ox);

  for (genvar yf = 0; yf < KMAX; yf++) begin : g_wy
    for (genvar xf = 0; xf < KMAX; xf++) begin : g_wx
      assign window[(yf*KMAX+xf)*PIX_W +: PIX_W] = mem[base + AW'(yf*ROW_W + xf)];
    end
  end

endmodule

// File: rtl/conv_mac_tree.sv
`timescale 1ns/1ps
module conv_mac_tree
  import conv_actor_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 16,
  parameter int KK     = 25,
  parameter int ACC_W  = 29
) (
  input  logic                   clk,
  input  logic                   load,
  input  logic [KK*PIX_W-1:0]    pix,
  input  logic [KK*COEF_W-1:0]   taps,
  output logic [ACC_W-1:0]       acc
);
  localparam int LV = clog2m(KK);
  localparam int NP = 1 << LV;

  for (genvar l = 0; l <= LV; l++) begin : g_lvl
    localparam int CNT = NP >> l;
    logic [ACC_W-1:0] s [CNT];
    for (genvar i = 0; i < CNT; i++) begin : g_n
      if (l == 0) begin : g_leaf
        if (i < KK) begin : g_mul
          assign s[i] = ACC_W'(pix[i*PIX_W +: PIX_W]) * ACC_W'(taps[i*COEF_W +: COEF_W]);
        end else begin : g_pad
          assign s[i] = '0;
        end
      end else begin : g_add
        assign s[i] = g_lvl[l-1].s[2*i] + g_lvl[l-1].s[2*i+1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (load) acc <= g_lvl[LV].s[0];
  end

endmodule

// File: rtl/conv_seq_div.sv
`timescale 1ns/1ps
module conv_seq_div #(
  parameter int NUM_W = 30,
  parameter int DEN_W = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int CW = $clog2(NUM_W + 1);

  logic [CW-1:0]    cnt_q;
  logic [DEN_W-1:0] rem_q, den_q, diff;
  logic [NUM_W-1:0] quo_q;
  logic [DEN_W:0]   shifted;
  logic             ge;

  always_comb begin
    shifted = {rem_q, quo_q[NUM_W-1]};
    ge      = shifted >= {1'b0, den_q};
    diff    = shifted[DEN_W-1:0] - den_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt_q <= '0;
      rem_q <= '0;
      den_q <= '0;
      quo_q <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q <= '0;
        quo_q <= num;
        den_q <= den;
        cnt_q <= CW'(NUM_W);
        busy  <= 1'b1;
      end else if (busy) begin
        rem_q <= ge ? diff : shifted[DEN_W-1:0];
        quo_q <= {quo_q[NUM_W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quo = quo_q;

  // R5: a division is only started on an idle divider, and done follows busy
  a_r5_start_idle: assert property (@(posedge clk) disable iff (rst) start |-> !busy);
  a_r5_done_after_busy: assert property (@(posedge clk) disable iff (rst) done |-> $past(busy));

endmodule

// File: rtl/conv_tile_actor.sv
`timescale 1ns/1ps
module conv_tile_actor
  import conv_actor_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 16,
  parameter int TILE_W = 4,
  parameter int TILE_H = 4,
  parameter int HALO   = 2,
  parameter int KMAX   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reload,
  input  logic              coef_empty,
  output logic              coef_rd,
  input  logic [COEF_W-1:0] coef_din,
  input  logic              tile_empty,
  output logic              tile_rd,
  input  logic [PIX_W-1:0]  tile_din,
  input  logic              out_full,
  output logic              out_wr,
  output logic [PIX_W-1:0]  out_dout,
  output logic              proc_mode
);
  localparam int ROW_W = TILE_W + 2*HALO;
  localparam int COL_H = TILE_H + 2*HALO;
  localparam int N_IN  = ROW_W * COL_H;
  localparam int KK    = KMAX * KMAX;
  localparam int SUM_W = COEF_W + clog2m(KK);
  localparam int ACC_W = PIX_W + COEF_W + clog2m(KK);
  localparam int NUM_W = ACC_W + 1;
  localparam int AW    = clog2m(N_IN);
  localparam int XW    = clog2m(TILE_W);
  localparam int YW    = clog2m(TILE_H);

  eng_state_e          st;
  logic [AW-1:0]       widx;
  logic [XW-1:0]       ox;
  logic [YW-1:0]       oy;
  logic                held, idle, clear;
  logic [KK*COEF_W-1:0] taps;
  logic [SUM_W-1:0]    tap_sum;
  logic [KK*PIX_W-1:0] window;
  logic [ACC_W-1:0]    acc;
  logic [NUM_W-1:0]    quo;
  logic                div_busy, div_done;

  assign proc_mode = held;
  assign idle      = (st == EN_FILL) && (widx == '0);
  assign clear     = reload && held && idle;
  assign tile_rd   = held && (st == EN_FILL) && !tile_empty && !clear;

  conv_coef_store #(.COEF_W(COEF_W), .KMAX(KMAX), .SUM_W(SUM_W)) u_coef (
    .clk(clk), .rst(rst), .clear(clear),
    .fifo_empty(coef_empty), .fifo_rd(coef_rd), .fifo_din(coef_din),
    .taps(taps), .tap_sum(tap_sum), .held(held)
  );

  conv_tile_buf #(.PIX_W(PIX_W), .ROW_W(ROW_W), .N_IN(N_IN), .KMAX(KMAX),
                  .XW(XW), .YW(YW)) u_buf (
    .clk(clk), .wr_en(tile_rd), .wr_addr(widx), .wr_data(tile_din),
    .ox(ox), .oy(oy), .window(window)
  );

  conv_mac_tree #(.PIX_W(PIX_W), .COEF_W(COEF_W), .KK(KK), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .load(st == EN_MAC), .pix(window), .taps(taps), .acc(acc)
  );

  conv_seq_div #(.NUM_W(NUM_W), .DEN_W(SUM_W)) u_div (
    .clk(clk), .rst(rst), .start(st == EN_DIVGO),
    .num(NUM_W'(acc) + NUM_W'(tap_sum >> 1)), .den(tap_sum),
    .busy(div_busy), .done(div_done), .quo(quo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= EN_FILL;
      widx     <= '0;
      ox       <= '0;
      oy       <= '0;
      out_wr   <= 1'b0;
      out_dout <= '0;
    end else begin
      out_wr <= 1'b0;
      case (st)
        EN_FILL: begin
          if (tile_rd) begin
            if (widx == AW'(N_IN - 1)) begin
              widx <= '0;
              ox   <= '0;
              oy   <= '0;
              st   <= EN_MAC;
            end else begin
              widx <= widx + 1'b1;
            end
          end
        end
        EN_MAC:   st <= EN_DIVGO;
        EN_DIVGO: st <= EN_DIVWAIT;
        EN_DIVWAIT: begin
          if (div_done) begin
            if (tap_sum == '0) out_dout <= '0;
            else if (|quo[NUM_W-1:PIX_W]) out_dout <= '1;
            else out_dout <= quo[PIX_W-1:0];
            st <= EN_EMIT;
          end
        end
        EN_EMIT: begin
          if (!out_full) begin
            out_wr <= 1'b1;
            if (ox == XW'(TILE_W - 1)) begin
              ox <= '0;
              if (oy == YW'(TILE_H - 1)) begin
                oy <= '0;
                st <= EN_FILL;
              end else begin
                oy <= oy + 1'b1;
                st <= EN_MAC;
              end
            end else begin
              ox <= ox + 1'b1;
              st <= EN_MAC;
            end
          end
        end
        default: st <= EN_FILL;
      endcase
    end
  end

  // R1: no tile token is taken while loading coefficients
  a_r1_no_tile_in_load: assert property (@(posedge clk) disable iff (rst)
    !proc_mode |-> !tile_rd);
  // R3: no coefficient token is taken while processing
  a_r3_no_coef_in_proc: assert property (@(posedge clk) disable iff (rst)
    proc_mode |-> !coef_rd);
  // R7: nothing is written while a tile is part-way in
  a_r7_no_write_mid_fill: assert property (@(posedge clk) disable iff (rst)
    (st == EN_FILL && widx != '0) |-> !out_wr);
  // R8: respect the output FIFO and emit single pulses
  a_r8_no_write_into_full: assert property (@(posedge clk) disable iff (rst)
    out_wr |-> !$past(out_full));
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_wr |=> !out_wr);
  // R9: leaving the processing mode needs a reload request
  a_r9_leave_on_reload: assert property (@(posedge clk) disable iff (rst)
    $fell(proc_mode) |-> $past(reload));
  // R5: the divider is not busy when a new window is captured
  a_r5_mac_div_order: assert property (@(posedge clk) disable iff (rst)
    (st == EN_MAC) |-> !div_busy);

endmodule

// File: tb/test_conv_tile_actor.sv
`timescale 1ns/1ps
module test_conv_tile_actor;
  localparam int ROW = 8;
  localparam int NIN = 64;
  localparam int TW  = 4;
  localparam int TH  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reload = 1'b0;
  logic coef_empty, coef_rd, tile_empty, tile_rd, out_full, out_wr, proc_mode;
  logic [15:0] coef_din;
  logic [7:0]  tile_din, out_dout;

  always #4 clk = ~clk;  // 125 MHz

  conv_tile_actor i_conv_tile_actor (
    .clk(clk), .rst(rst), .reload(reload),
    .coef_empty(coef_empty), .coef_rd(coef_rd), .coef_din(coef_din),
    .tile_empty(tile_empty), .tile_rd(tile_rd), .tile_din(tile_din),
    .out_full(out_full), .out_wr(out_wr), .out_dout(out_dout),
    .proc_mode(proc_mode)
  );

  int total = 0;
  int bad = 0;
  logic [15:0] cq[$];
  logic [7:0]  tq[$];
  int          exp_q[$];
  string       tag_q[$];
  int  tile_pops = 0;
  int  cyc = 0;
  bit  stall = 0;
  int  cur_px [NIN];
  int  mk [5][5];
  int  mrows = 0, mcols = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // FIFO models: pops decided by the strobes seen mid-cycle
  initial begin
    coef_empty = 1'b1; tile_empty = 1'b1; coef_din = '0; tile_din = '0; out_full = 1'b0;
    forever begin
      logic crd, trd;
      @(negedge clk);
      crd = coef_rd; trd = tile_rd;
      @(posedge clk);
      #1;
      if (!rst && crd && cq.size() > 0) void'(cq.pop_front());
      if (!rst && trd && tq.size() > 0) begin void'(tq.pop_front()); tile_pops++; end
      #2;
      cyc++;
      coef_empty = (cq.size() == 0);
      coef_din   = (cq.size() > 0) ? cq[0] : '0;
      tile_empty = (tq.size() == 0);
      tile_din   = (tq.size() > 0) ? tq[0] : '0;
      out_full   = stall && (cyc % 3 != 0);
    end
  end

  // Monitor / scoreboard
  initial begin
    logic last_full;
    last_full = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst && out_wr) begin
        chk(last_full == 1'b0, "R8 write after full", 1, 0);
        chk(tile_pops % NIN == 0 && tile_pops > 0, "R7 write before tile complete", tile_pops % NIN, 0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected write", out_dout, -1);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(out_dout == e, t, out_dout, e);
        end
      end
      last_full = out_full;
    end
  end

  task automatic gen_tile(input int seed);
    for (int i = 0; i < NIN; i++) cur_px[i] = (seed*71 + i*29 + ((i*i) >> 2)) % 256;
  endtask

  task automatic push_px(input int lo, input int hi);
    for (int i = lo; i <= hi; i++) tq.push_back(8'(cur_px[i]));
  endtask

  // Model of R5/R6 using the kernel the bench loaded
  task automatic expect_tile(input string tag);
    int s;
    s = 0;
    for (int r = 0; r < mrows; r++) for (int c = 0; c < mcols; c++) s += mk[r][c];
    for (int y = 0; y < TH; y++) begin
      for (int x = 0; x < TW; x++) begin
        int a;
        a = 0;
        for (int r = 0; r < mrows; r++)
          for (int c = 0; c < mcols; c++)
            a += mk[r][c] * cur_px[(y+r)*ROW + x + c];
        exp_q.push_back((s == 0) ? 0 : (a + s/2) / s);
        tag_q.push_back(tag);
      end
    end
  endtask

  task automatic push_taps();
    for (int r = 0; r < mrows; r++) for (int c = 0; c < mcols; c++) cq.push_back(16'(mk[r][c]));
  endtask

  task automatic push_kernel();
    cq.push_back(16'(mrows));
    cq.push_back(16'(mcols));
    push_taps();
  endtask

  task automatic wait_mode(input logic v);
    for (int i = 0; i < 2000 && proc_mode != v; i++) step(1);
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 20000 && (exp_q.size() != 0 || tq.size() != 0); i++) step(1);
    step(5);
  endtask

  task automatic pulse_reload();
    @(posedge clk); #2 reload = 1'b1;
    @(posedge clk); #2 reload = 1'b0;
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int b [5];
    b = '{1, 4, 6, 4, 1};
    step(4);
    rst = 1'b0;
    step(1);
    // R1: reset state
    chk(proc_mode == 1'b0, "R1 mode after reset", proc_mode, 0);
    chk(out_wr == 1'b0, "R1 out_wr after reset", out_wr, 0);
    gen_tile(1);
    push_px(0, NIN-1);
    step(20);
    chk(tq.size() == NIN, "R1 tile tokens held in load mode", tq.size(), NIN);

    // R2/R3: load 5x5 binomial kernel
    mrows = 5; mcols = 5;
    for (int r = 0; r < 5; r++) for (int c = 0; c < 5; c++) mk[r][c] = b[r]*b[c];
    push_kernel();
    wait_mode(1'b1);
    chk(proc_mode == 1'b1, "R3 mode after vector", proc_mode, 1);
    chk(cq.size() == 0, "R2 whole vector consumed", cq.size(), 0);
    expect_tile("R5 5x5 tile");
    wait_drain();
    chk(proc_mode == 1'b1, "R3 mode stays after tile", proc_mode, 1);

    // R3: coefficient tokens wait in processing mode; R8 stalls
    cq.push_back(16'd3);
    cq.push_back(16'd2);
    gen_tile(2);
    push_px(0, NIN-1);
    expect_tile("R8 stalled tile");
    stall = 1'b1;
    wait_drain();
    stall = 1'b0;
    chk(cq.size() == 2, "R3 coef tokens untouched", cq.size(), 2);

    // R9: reload mid-tile is ignored
    gen_tile(3);
    push_px(0, 29);
    step(40);
    pulse_reload();
    step(4);
    chk(proc_mode == 1'b1, "R9 reload mid-tile ignored", proc_mode, 1);
    push_px(30, NIN-1);
    expect_tile("R9 tile after ignored reload");
    wait_drain();

    // R9: reload when idle, new 3x2 kernel (header already queued)
    pulse_reload();
    mrows = 3; mcols = 2;
    mk[0][0] = 1; mk[0][1] = 2; mk[1][0] = 3; mk[1][1] = 1; mk[2][0] = 1; mk[2][1] = 1;
    step(1);
    chk(proc_mode == 1'b0, "R9 back to load mode", proc_mode, 0);
    push_taps();
    wait_mode(1'b1);
    chk(cq.size() == 0, "R2 3x2 vector consumed", cq.size(), 0);
    gen_tile(4);
    push_px(0, NIN-1);
    expect_tile("R9 new kernel 3x2");
    wait_drain();

    // R6: zero-sum kernel
    pulse_reload();
    mrows = 1; mcols = 1; mk[0][0] = 0;
    push_kernel();
    wait_mode(1'b1);
    gen_tile(5);
    push_px(0, NIN-1);
    expect_tile("R6 zero sum");
    wait_drain();

    // R4: single tap picks p[y*stride+x]
    pulse_reload();
    mrows = 1; mcols = 1; mk[0][0] = 9;
    push_kernel();
    wait_mode(1'b1);
    gen_tile(6);
    push_px(0, NIN-1);
    expect_tile("R4 stride indexing");
    wait_drain();

    chk(exp_q.size() == 0, "R7 all outputs written", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule